// File: doc/BRIEF.md
# Two-Bank GPIO Controller with Edge Interrupts

This block is a general-purpose I/O controller. Its pins are divided into a low "core" bank and a high "resume" bank at a boundary index set by a parameter. Each bank has the same eight per-pin registers. One register gates the pin driver, one picks the direction, one holds the level, two select rising or falling edge triggers, one enables the event, one is a spare interrupt-routing enable, and one holds the trigger status. Software reaches them through a simple word-wide register port with byte enables. A one-lane write is an 8-bit access, and reading a whole word returns the full 32-bit status of a bank.

Input pins are synchronised and compared with their previous sampled value. An edge that matches a pin's trigger selection sets that pin's status bit, and the bit stays set until software writes 1 to it. A single level-sensitive event output is high while any pending status bit has its event enable set, in either bank. Software rebuilds a flat pending vector as the resume-bank status shifted left by the boundary, ORed with the core-bank status.

Top module: `gpio2b_ctrl`

## Requirements
- R1: Register word `reg_addr` maps to byte offset `reg_addr*4`. Bit 3 of `reg_addr` selects the bank: 0 is core (offsets 0x00..0x1C) and 1 is resume (0x20..0x3C). Bits 2:0 select the register: 0 enable, 1 direction, 2 level, 3 rising trigger, 4 falling trigger, 5 event enable, 6 spare routing enable, 7 trigger status. `rdata` is combinational from `reg_addr`.
- R2: Pin g belongs to the core bank as local pin g when g < RESUME_BASE. Otherwise it belongs to the resume bank as local pin g-RESUME_BASE. Local pin n is bit n of the bank word, which is bit n%8 of byte lane n/8. Bits at or above a bank's width read 0 and ignore writes.
- R3: Direction bit 1 means input and 0 means output. `pin_oe[g]` is 1 exactly when the pin's enable bit is 1 and its direction bit is 0. `pin_out[g]` carries the stored level bit.
- R4: Synchronous active-high reset sets every direction bit to 1 and clears enable, level, trigger, event, spare and status bits. After reset `pin_oe` is 0 and `event_o` is 0.
- R5: Reading the level register returns the stored bit for driven pins (`pin_oe`=1) and the synchronised input for all other pins.
- R6: Inputs pass through two flops. A change applied before clock edge E0 appears in a level read after edge E1, and in trigger status after edge E2.
- R7: A rising trigger latches status on 0-to-1, a falling trigger latches on 1-to-0, and both together latch on either edge. With neither set, edges never set status.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a clear and a new edge for the same pin land in the same cycle, the bit stays set.
- R9: `event_o` is 1 exactly while some status bit in either bank has its event enable bit set.
- R10: The spare routing enable register stores and reads back its value and has no effect on `event_o`, status or pins.
- R11: A write changes only the byte lanes whose `be` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| reg_addr | input | 4 | Word address: bit 3 bank, bits 2:0 register |
| wdata | input | 32 | Write data, byte lane k on bits 8k+7:8k |
| be | input | 4 | Byte-lane write enables |
| rdata | output | 32 | Read data of the addressed register |
| pin_in | input | N_PINS | Raw pin inputs |
| pin_out | output | N_PINS | Pin output values |
| pin_oe | output | N_PINS | Pin output enables |
| event_o | output | 1 | Level-sensitive event request |

## Verification
The bench aims at the synchroniser latency: a design one stage short latches status a cycle early, and one stage long latches it a cycle late. It drives a clear in the same cycle as a fresh edge on the same pin. A design that lets the clear win loses that interrupt. It writes all-ones to the narrow resume bank and uses single-lane writes, which expose padding bits that read as nonzero and lanes written without their enable. It also checks the bank split of event, direction and level readback, which shows up when resume pins are mapped onto the wrong global index.

// File: rtl/gpio2b_pkg.sv
package gpio2b_pkg;

    localparam int WORD_BITS = 32;
    localparam int LANES     = WORD_BITS / 8;

    typedef enum logic [2:0] {
        RG_ENABLE = 3'd0,
        RG_DIR    = 3'd1,
        RG_LEVEL  = 3'd2,
        RG_RISE   = 3'd3,
        RG_FALL   = 3'd4,
        RG_EVENT  = 3'd5,
        RG_SPARE  = 3'd6,
        RG_STATUS = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic                 wr;
        reg_sel_e             sel;
        logic [WORD_BITS-1:0] data;
        logic [WORD_BITS-1:0] mask;
    } bank_req_t;

    function automatic logic [WORD_BITS-1:0] lane_mask(input logic [LANES-1:0] be);
        logic [WORD_BITS-1:0] m;
        for (int k = 0; k < LANES; k++) begin
            m[k*8 +: 8] = {8{be[k]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio2b_sync.sv
module gpio2b_sync #(
    parameter int WIDTH = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign synced = sync_q;
    assign rise   = sync_q & ~prev_q;
    assign fall   = ~sync_q & prev_q;
endmodule

// File: rtl/gpio2b_bank.sv
module gpio2b_bank
    import gpio2b_pkg::*;
#(
    parameter int WIDTH = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  bank_req_t            req,
    input  logic [WIDTH-1:0]     pin_sync,
    input  logic [WIDTH-1:0]     rise,
    input  logic [WIDTH-1:0]     fall,
    output logic [WORD_BITS-1:0] rd_word,
    output logic [WIDTH-1:0]     drive_en,
    output logic [WIDTH-1:0]     drive_val,
    output logic [WIDTH-1:0]     status,
    output logic [WIDTH-1:0]     event_en,
    output logic [WIDTH-1:0]     trig_en
);
    logic [WIDTH-1:0] en_q, dir_q, lvl_q, rte_q, fte_q, evt_q, spr_q, sts_q;
    logic [WIDTH-1:0] wd, wm, clr, hit;

    assign wd  = req.data[WIDTH-1:0];
    assign wm  = req.mask[WIDTH-1:0];
    assign clr = (req.wr && req.sel == RG_STATUS) ? (wd & wm) : '0;
    assign hit = (rise & rte_q) | (fall & fte_q);

    function automatic logic [WIDTH-1:0] merge(input logic [WIDTH-1:0] old);
        return (old & ~wm) | (wd & wm);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            dir_q <= '1;
            lvl_q <= '0;
            rte_q <= '0;
            fte_q <= '0;
            evt_q <= '0;
            spr_q <= '0;
            sts_q <= '0;
        end else begin
            if (req.wr) begin
                case (req.sel)
                    RG_ENABLE: en_q  <= merge(en_q);
                    RG_DIR:    dir_q <= merge(dir_q);
                    RG_LEVEL:  lvl_q <= merge(lvl_q);
                    RG_RISE:   rte_q <= merge(rte_q);
                    RG_FALL:   fte_q <= merge(fte_q);
                    RG_EVENT:  evt_q <= merge(evt_q);
                    RG_SPARE:  spr_q <= merge(spr_q);
                    default:   ;
                endcase
            end
            sts_q <= (sts_q & ~clr) | hit;
        end
    end

    assign drive_en  = en_q & ~dir_q;
    assign drive_val = lvl_q;
    assign status    = sts_q;
    assign event_en  = evt_q;
    assign trig_en   = rte_q | fte_q;

    always_comb begin
        rd_word = '0;
        case (req.sel)
            RG_ENABLE: rd_word[WIDTH-1:0] = en_q;
            RG_DIR:    rd_word[WIDTH-1:0] = dir_q;
            RG_LEVEL:  rd_word[WIDTH-1:0] = (drive_en & lvl_q) | (~drive_en & pin_sync);
            RG_RISE:   rd_word[WIDTH-1:0] = rte_q;
            RG_FALL:   rd_word[WIDTH-1:0] = fte_q;
            RG_EVENT:  rd_word[WIDTH-1:0] = evt_q;
            RG_SPARE:  rd_word[WIDTH-1:0] = spr_q;
            default:   rd_word[WIDTH-1:0] = sts_q;
        endcase
    end
endmodule

// File: rtl/gpio2b_ctrl.sv
module gpio2b_ctrl
    import gpio2b_pkg::*;
#(
    parameter int N_PINS      = 14,
    parameter int RESUME_BASE = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       wdata,
    input  logic [3:0]        be,
    output logic [31:0]       rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    output logic              event_o
);
    localparam int CORE_W = RESUME_BASE;
    localparam int RES_W  = N_PINS - RESUME_BASE;

    logic [N_PINS-1:0] synced, rise, fall;
    logic [N_PINS-1:0] status_all, evten_all, trig_all;
    logic [31:0]       rd_w [2];
    logic [31:0]       mask_w;

    assign mask_w = lane_mask(be);

    gpio2b_sync #(.WIDTH(N_PINS)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (pin_in),
        .synced (synced),
        .rise   (rise),
        .fall   (fall)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        localparam int W  = (b == 0) ? CORE_W : RES_W;
        localparam int LO = (b == 0) ? 0 : CORE_W;
        bank_req_t req;

        assign req.wr   = wr_en && (reg_addr[3] == 1'(b));
        assign req.sel  = reg_sel_e'(reg_addr[2:0]);
        assign req.data = wdata;
        assign req.mask = mask_w;

        gpio2b_bank #(.WIDTH(W)) u_bank (
            .clk       (clk),
            .rst       (rst),
            .req       (req),
            .pin_sync  (synced[LO +: W]),
            .rise      (rise[LO +: W]),
            .fall      (fall[LO +: W]),
            .rd_word   (rd_w[b]),
            .drive_en  (pin_oe[LO +: W]),
            .drive_val (pin_out[LO +: W]),
            .status    (status_all[LO +: W]),
            .event_en  (evten_all[LO +: W]),
            .trig_en   (trig_all[LO +: W])
        );
    end

    assign rdata   = rd_w[reg_addr[3]];
    assign event_o = |(status_all & evten_all);
endmodule

// File: rtl/gpio2b_checker.sv
module gpio2b_checker #(
    parameter int N_PINS      = 14,
    parameter int RESUME_BASE = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [3:0]        reg_addr,
    input logic [31:0]       rdata,
    input logic [N_PINS-1:0] pin_oe,
    input logic              event_o,
    input logic [N_PINS-1:0] st_all,
    input logic [N_PINS-1:0] trig_all
);
    localparam logic [31:0] CORE_MASK = (32'h1 << RESUME_BASE) - 32'h1;
    localparam logic [31:0] RES_MASK  = (32'h1 << (N_PINS - RESUME_BASE)) - 32'h1;

    // R4: reset leaves no driver on and no event
    p_reset_quiet_r4: assert property (@(posedge clk)
        rst |=> (pin_oe == '0 && !event_o));

    // R2: bits above a bank's width read as zero
    p_pad_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (rdata & ~(reg_addr[3] ? RES_MASK : CORE_MASK)) == 32'h0);

    // R8: a status bit only drops after a write to a status register
    p_clear_needs_write_r8: assert property (@(posedge clk) disable iff (rst)
        (|($past(st_all) & ~st_all)) |-> ($past(wr_en) && $past(reg_addr[2:0]) == 3'd7));

    // R7: a status bit only rises on a pin with a trigger selected
    p_set_needs_trigger_r7: assert property (@(posedge clk) disable iff (rst)
        ((st_all & ~$past(st_all) & ~$past(trig_all)) == '0));

    // R9: the event only rises when status or event enables changed
    p_event_rise_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(event_o) |-> (!$stable(st_all) || $past(wr_en)));
endmodule

bind gpio2b_ctrl gpio2b_checker #(
    .N_PINS      (N_PINS),
    .RESUME_BASE (RESUME_BASE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .reg_addr (reg_addr),
    .rdata    (rdata),
    .pin_oe   (pin_oe),
    .event_o  (event_o),
    .st_all   (status_all),
    .trig_all (trig_all)
);

// File: tb/sim_gpio2b_ctrl.sv
module sim_gpio2b_ctrl;
    localparam int N = 14;
    localparam int B = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [31:0]   wdata = '0;
    logic [3:0]    be = '0;
    logic [31:0]   rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out, pin_oe;
    logic          event_o;

    int chk_cnt = 0;
    int fail_cnt = 0;

    always #5 clk = ~clk;

    gpio2b_ctrl #(.N_PINS(N), .RESUME_BASE(B)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .reg_addr(reg_addr), .wdata(wdata),
        .be(be), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .event_o(event_o)
    );

    // behavioural reference, global pin indexing
    logic [N-1:0] m_s1, m_s2, m_p;
    logic [N-1:0] m_en, m_dir, m_lvl, m_rte, m_fte, m_ev, m_spr, m_st;

    always @(posedge clk) begin
        logic [N-1:0] setv, nst;
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_p = '0;
            m_en = '0; m_dir = '1; m_lvl = '0; m_rte = '0; m_fte = '0;
            m_ev = '0; m_spr = '0; m_st = '0;
        end else begin
            setv = ((m_s2 & ~m_p) & m_rte) | ((~m_s2 & m_p) & m_fte);
            nst = m_st;
            if (wr_en) begin
                for (int n = 0; n < 32; n++) begin
                    int g, lim;
                    g   = reg_addr[3] ? B + n : n;
                    lim = reg_addr[3] ? N - B : B;
                    if (be[n/8] && n < lim) begin
                        case (reg_addr[2:0])
                            3'd0: m_en[g]  = wdata[n];
                            3'd1: m_dir[g] = wdata[n];
                            3'd2: m_lvl[g] = wdata[n];
                            3'd3: m_rte[g] = wdata[n];
                            3'd4: m_fte[g] = wdata[n];
                            3'd5: m_ev[g]  = wdata[n];
                            3'd6: m_spr[g] = wdata[n];
                            default: if (wdata[n]) nst[g] = 1'b0;
                        endcase
                    end
                end
            end
            m_st = nst | setv;
            m_p  = m_s2;
            m_s2 = m_s1;
            m_s1 = pin_in;
        end
    end

    function automatic logic [31:0] model_read(input logic [3:0] a);
        logic [31:0] r;
        r = '0;
        for (int n = 0; n < 32; n++) begin
            int g, lim;
            g   = a[3] ? B + n : n;
            lim = a[3] ? N - B : B;
            if (n < lim) begin
                case (a[2:0])
                    3'd0: r[n] = m_en[g];
                    3'd1: r[n] = m_dir[g];
                    3'd2: r[n] = (m_en[g] && !m_dir[g]) ? m_lvl[g] : m_s2[g];
                    3'd3: r[n] = m_rte[g];
                    3'd4: r[n] = m_fte[g];
                    3'd5: r[n] = m_ev[g];
                    3'd6: r[n] = m_spr[g];
                    default: r[n] = m_st[g];
                endcase
            end
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        chk_cnt++;
        if (got !== exp) begin
            fail_cnt++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare_model();
        string t;
        case (reg_addr[2:0])
            3'd2:    t = "R5 level read";
            3'd6:    t = "R10 spare read";
            3'd7:    t = "R8 status read";
            default: t = "R1 register read";
        endcase
        check(t, rdata, model_read(reg_addr));
        check("R3 pin_oe", 32'(pin_oe), 32'(m_en & ~m_dir));
        check("R3 pin_out", 32'(pin_out), 32'(m_lvl));
        check("R9 event_o", 32'(event_o), 32'(|(m_st & m_ev)));
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
        if (!rst) compare_model();
    endtask

    task automatic wr(input logic [7:0] off, input logic [31:0] d, input logic [3:0] lanes);
        reg_addr = off[5:2]; wdata = d; be = lanes; wr_en = 1'b1;
        cyc();
        wr_en = 1'b0; be = '0;
    endtask

    task automatic rd(input logic [7:0] off);
        reg_addr = off[5:2];
        cyc();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fail_cnt++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
        $finish;
    end

    initial begin
        logic [31:0] core_st;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        // R4 reset state
        rd(8'h04); check("R4 core dir reset", rdata, 32'h3FF);
        rd(8'h24); check("R4 resume dir reset", rdata, 32'hF);
        rd(8'h1C); check("R4 status reset", rdata, 32'h0);
        check("R4 event reset", 32'(event_o), 32'h0);
        check("R4 oe reset", 32'(pin_oe), 32'h0);

        // R3 direction and enable
        wr(8'h00, 32'h0F, 4'h1);
        wr(8'h04, 32'h3FC, 4'h3);
        wr(8'h08, 32'h01, 4'h1);
        check("R3 oe core", 32'(pin_oe), 32'h0003);
        rd(8'h08); check("R5 level mixed", rdata, 32'h1);

        // R2 resume bank mapping and padding
        wr(8'h20, 32'hFFFF_FFFF, 4'hF);
        rd(8'h20); check("R2 resume enable pad", rdata, 32'hF);
        wr(8'h24, 32'h0, 4'h1);
        check("R2 resume oe index", 32'(pin_oe), 32'h3C03);
        wr(8'h28, 32'h5, 4'h1);
        check("R2 resume pin_out", 32'(pin_out), 32'h1401);
        wr(8'h24, 32'hF, 4'h1);

        // R11 byte lanes
        wr(8'h00, 32'hFFFF_FF00, 4'h2);
        rd(8'h00); check("R11 lane1 only", rdata, 32'h30F);

        // R6 / R5 input latency and level read
        reg_addr = 4'h2;
        pin_in = 14'h0012;
        cyc(); check("R6 level after one edge", rdata, 32'h001);
        cyc(); check("R6 level after two edges", rdata, 32'h011);
        cyc();
        rd(8'h1C); check("R7 no trigger no status", rdata, 32'h0);

        // R7 rising, falling, both
        wr(8'h0C, 32'hA0, 4'h1);
        wr(8'h10, 32'hC0, 4'h1);
        reg_addr = 4'h7;
        pin_in = 14'h00F2;
        cyc(); cyc(); check("R6 status not yet", rdata, 32'h0);
        cyc(); check("R7 rising", rdata, 32'hA0);
        pin_in = 14'h0012;
        cyc(); cyc(); cyc(); check("R7 falling and both", rdata, 32'hE0);

        // R9 event enable
        wr(8'h14, 32'h40, 4'h1);
        check("R9 event set", 32'(event_o), 32'h1);

        // R8 clear semantics
        wr(8'h1C, 32'h00, 4'h1); check("R8 write zero keeps", rdata, 32'hE0);
        wr(8'h1C, 32'h40, 4'h1); check("R8 write one clears", rdata, 32'hA0);
        check("R9 event drops", 32'(event_o), 32'h0);
        pin_in = 14'h0032;
        cyc(); cyc();
        wr(8'h1C, 32'hA0, 4'h1); check("R8 set wins over clear", rdata, 32'h20);

        // R10 spare register
        wr(8'h18, 32'hFF, 4'h1); check("R10 spare readback", rdata, 32'hFF);
        check("R10 no event", 32'(event_o), 32'h0);
        rd(8'h1C); check("R10 status untouched", rdata, 32'h20);

        // R2 / R9 resume edge and combined pending
        wr(8'h2C, 32'h2, 4'h1);
        wr(8'h34, 32'h2, 4'h1);
        pin_in = 14'h0832;
        cyc(); cyc(); cyc();
        rd(8'h3C); check("R2 resume status", rdata, 32'h2);
        check("R9 resume event", 32'(event_o), 32'h1);
        rd(8'h1C); core_st = rdata;
        rd(8'h3C);
        check("R2 combined pending", (rdata << B) | core_st, 32'h820);
        wr(8'h3C, 32'h2, 4'h1);
        check("R8 resume ack", rdata, 32'h0);
        check("R9 event after ack", 32'(event_o), 32'h0);

        repeat (4) cyc();
        $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
        $finish;
    end
endmodule